// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block divides a reference clock by an integer taken from a small code field inside a 32-bit control register. A build-time encoding choice decides how the code becomes a divisor. The choices are code plus one, the raw code (with an optional zero-means-bypass rule), two raised to the code, or a computed lookup table. Software writes the register through a single-cycle write strobe and reads it back on a plain read data port. The divided clock leaves on one output, and a status bit reports when the current code does not give a usable divisor.

The code field's position and width are parameters. An optional masked-write mode keeps the field inside the low half-word and uses the high half-word as a per-bit write enable. An optional locked mode freezes the field at its reset value. A newly written divisor is taken up only when the running output period ends, so the output never shows a shortened pulse.

Top module: `rdiv_top`

## Requirements
- R1: With ENC = ENC_PLUS1 the divisor is the field code plus one; code 0 gives divide-by-one, where divClk follows refClk.
- R2: With ENC = ENC_RAW and ALLOW_ZERO = 0 the divisor is the code itself. Code 0 is invalid: badCode reads 1 and divClk stays low.
- R3: With ENC = ENC_RAW and ALLOW_ZERO = 1, code 0 selects bypass (divClk follows refClk, badCode 0); other codes divide by the code.
- R4: With ENC = ENC_POW2 the divisor is 2 to the power of the code. A divisor above 2^DIV_W - 1 (255 by default) is invalid and sets badCode.
- R5: With ENC = ENC_TABLE, a code k below TBL_LEN divides by 2k+3. Any code at or above TBL_LEN falls past the table's zero terminator and is invalid.
- R6: With HIWORD = 1, field bit i (register bit SHIFT+i, SHIFT+WIDTH <= 16) takes the value of wrData[SHIFT+i] only if wrData[16+SHIFT+i] is 1; otherwise it keeps its value.
- R7: With READ_ONLY = 1, writes never change the field, so rdData stays 0.
- R8: The field occupies rdData[SHIFT+WIDTH-1:SHIFT]; all other read bits are 0. Without HIWORD a write copies wrData[SHIFT+WIDTH-1:SHIFT] into the field.
- R9: A changed divisor takes effect only after the current output period completes; the period in progress keeps its old high and low lengths.
- R10: For a divisor d >= 2, divClk is high for (d+1)/2 and low for d/2 refClk cycles (integer division), starting high.
- R11: Reset clears the field to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; also clocks the register |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle register write strobe |
| wrData | input | 32 | Write data (upper half is the bit mask in masked mode) |
| rdData | output | 32 | Register read-back |
| divClk | output | 1 | Divided clock |
| badCode | output | 1 | High while the current code gives no valid divisor |

## Verification
The bench builds six copies side by side on one write bus. There is one copy for each encoding: code plus one, raw code, raw code with zero-bypass, power of two and table. A masked-write build covers the raw encoding and a locked build covers code plus one. All use SHIFT = 4 and WIDTH = 4. Four-bit codes push the power-of-two copy past the 8-bit counter and the table copy past its five entries, so the invalid paths are reachable. Divisors from 1 to 128 cover bypass, even and odd duty cycles. Random masks on the shared bus drive the masked copy through partial updates.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  localparam int DIV_W = 8;

  typedef enum logic [1:0] {ENC_PLUS1, ENC_RAW, ENC_POW2, ENC_TABLE} divEnc_e;

  // Control-to-datapath strobes: decoded divisor and its qualifiers
  typedef struct packed {
    logic             valid;
    logic             bypass;
    logic [DIV_W-1:0] div;
  } divCfg_t;

  // Computed lookup: entries past len read as zero, the terminator
  function automatic logic [31:0] tableDiv(input logic [31:0] code, input int unsigned len);
    return (code < len) ? (2 * code + 3) : 32'd0;
  endfunction
endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter divEnc_e     ENC        = ENC_PLUS1,
  parameter bit          ALLOW_ZERO = 1'b0,
  parameter bit          HIWORD     = 1'b0,
  parameter bit          READ_ONLY  = 1'b0,
  parameter int          SHIFT      = 4,
  parameter int          WIDTH      = 4,
  parameter int unsigned TBL_LEN    = 5
) (
  input  logic        refClk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output divCfg_t     cfg
);
  localparam logic [31:0] MAX_DIV = (32'd1 << DIV_W) - 32'd1;

  logic [WIDTH-1:0] field;
  logic [WIDTH-1:0] nextField;
  logic [31:0]      fullDiv;
  logic             zeroBypass;

  generate
    if (HIWORD) begin : g_masked
      logic [WIDTH-1:0] bitEn;
      assign bitEn     = wrData[16+SHIFT +: WIDTH];
      assign nextField = (field & ~bitEn) | (wrData[SHIFT +: WIDTH] & bitEn);
    end else begin : g_plain
      assign nextField = wrData[SHIFT +: WIDTH];
    end
  endgenerate

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      field <= '0;
    end else if (wrEn && !READ_ONLY) begin
      field <= nextField;
    end
  end

  assign rdData = 32'(field) << SHIFT;

  always_comb begin
    zeroBypass = 1'b0;
    unique case (ENC)
      ENC_PLUS1: fullDiv = 32'(field) + 32'd1;
      ENC_RAW: begin
        fullDiv = 32'(field);
        if (ALLOW_ZERO && field == '0) begin
          fullDiv    = 32'd1;
          zeroBypass = 1'b1;
        end
      end
      ENC_POW2:  fullDiv = 32'd1 << field;
      default:   fullDiv = tableDiv(32'(field), TBL_LEN);
    endcase
  end

  assign cfg.valid  = (fullDiv != 32'd0) && (fullDiv <= MAX_DIV);
  assign cfg.bypass = cfg.valid && ((fullDiv == 32'd1) || zeroBypass);
  assign cfg.div    = fullDiv[DIV_W-1:0];
endmodule

// File: rtl/rdiv_core.sv
module rdiv_core
  import rdiv_pkg::*;
(
  input  logic    refClk,
  input  logic    rstN,
  input  divCfg_t cfg,
  output logic    divClk
);
  logic [DIV_W-1:0] actDiv;
  logic             actValid;
  logic             actBypass;
  logic [DIV_W-1:0] cnt;
  logic             outReg;
  logic             periodEnd;
  logic [DIV_W:0]   hiCnt;
  logic [DIV_W:0]   cntNext;

  assign hiCnt     = ({1'b0, actDiv} + 1'b1) >> 1;
  assign cntNext   = {1'b0, cnt} + 1'b1;
  assign periodEnd = !actValid || actBypass || (cntNext == {1'b0, actDiv});

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      actDiv    <= '0;
      actValid  <= 1'b0;
      actBypass <= 1'b0;
      cnt       <= '0;
      outReg    <= 1'b0;
    end else if (periodEnd) begin
      actDiv    <= cfg.div;
      actValid  <= cfg.valid;
      actBypass <= cfg.bypass;
      cnt       <= '0;
      outReg    <= cfg.valid && !cfg.bypass;
    end else begin
      cnt       <= cntNext[DIV_W-1:0];
      outReg    <= cntNext < hiCnt;
    end
  end

  assign divClk = actBypass ? refClk : outReg;
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top
  import rdiv_pkg::*;
#(
  parameter divEnc_e     ENC        = ENC_PLUS1,
  parameter bit          ALLOW_ZERO = 1'b0,
  parameter bit          HIWORD     = 1'b0,
  parameter bit          READ_ONLY  = 1'b0,
  parameter int          SHIFT      = 4,
  parameter int          WIDTH      = 4,
  parameter int unsigned TBL_LEN    = 5
) (
  input  logic        refClk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        divClk,
  output logic        badCode
);
  divCfg_t cfg;

  rdiv_ctrl #(
    .ENC(ENC), .ALLOW_ZERO(ALLOW_ZERO), .HIWORD(HIWORD), .READ_ONLY(READ_ONLY),
    .SHIFT(SHIFT), .WIDTH(WIDTH), .TBL_LEN(TBL_LEN)
  ) uCtrl (
    .refClk(refClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cfg(cfg)
  );

  rdiv_core uCore (
    .refClk(refClk), .rstN(rstN), .cfg(cfg), .divClk(divClk)
  );

  assign badCode = !cfg.valid;
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker
  import rdiv_pkg::*;
#(
  parameter bit HIWORD    = 1'b0,
  parameter bit READ_ONLY = 1'b0
) (
  input logic             refClk,
  input logic             rstN,
  input logic             wrEn,
  input logic [31:0]      wrData,
  input logic [31:0]      rdData,
  input logic [DIV_W-1:0] actDiv,
  input logic             actValid,
  input logic             actBypass,
  input logic [DIV_W-1:0] cnt,
  input logic             outReg
);
  // R7: locked field never moves after a write
  p_locked_hold_r7: assert property (@(posedge refClk) disable iff (!rstN)
    (READ_ONLY && wrEn) |=> $stable(rdData));

  // R6: a masked write with an empty mask leaves the field alone
  p_empty_mask_r6: assert property (@(posedge refClk) disable iff (!rstN)
    (HIWORD && wrEn && wrData[31:16] == 16'h0) |=> $stable(rdData));

  // R2: with no valid divisor taken up, the output is held low
  p_invalid_low_r2: assert property (@(posedge refClk) disable iff (!rstN)
    !actValid |-> !outReg);

  // R10: the phase counter stays inside the active period
  p_cnt_range_r10: assert property (@(posedge refClk) disable iff (!rstN)
    (actValid && !actBypass) |-> (cnt < actDiv));

  // R9: mid-period the active divisor cannot be replaced
  p_swap_at_end_r9: assert property (@(posedge refClk) disable iff (!rstN)
    (actValid && !actBypass && (cnt != actDiv - 1'b1)) |=> $stable(actDiv));
endmodule

bind rdiv_top rdiv_checker #(.HIWORD(HIWORD), .READ_ONLY(READ_ONLY)) uChk (
  .refClk(refClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .actDiv(uCore.actDiv), .actValid(uCore.actValid), .actBypass(uCore.actBypass),
  .cnt(uCore.cnt), .outReg(uCore.outReg)
);

// File: tb/rdiv_top_test.sv
module rdiv_top_test;
  import rdiv_pkg::*;

  localparam int NINST = 6;
  localparam int SETTLE = 300;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rd [NINST];
  logic [NINST-1:0] dclk;
  logic [NINST-1:0] bad;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int fieldModel [NINST];

  always #5 refClk = ~refClk;

  // 0 plus-one, 1 raw masked, 2 raw zero-bypass, 3 pow2, 4 table, 5 plus-one locked
  rdiv_top #(.ENC(ENC_PLUS1)) uut (.refClk(refClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rd[0]), .divClk(dclk[0]), .badCode(bad[0]));
  rdiv_top #(.ENC(ENC_RAW), .HIWORD(1'b1)) uutRaw (.refClk(refClk), .rstN(rstN), .wrEn(wrEn),
    .wrData(wrData), .rdData(rd[1]), .divClk(dclk[1]), .badCode(bad[1]));
  rdiv_top #(.ENC(ENC_RAW), .ALLOW_ZERO(1'b1)) uutZero (.refClk(refClk), .rstN(rstN), .wrEn(wrEn),
    .wrData(wrData), .rdData(rd[2]), .divClk(dclk[2]), .badCode(bad[2]));
  rdiv_top #(.ENC(ENC_POW2)) uutPow (.refClk(refClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rd[3]), .divClk(dclk[3]), .badCode(bad[3]));
  rdiv_top #(.ENC(ENC_TABLE)) uutTbl (.refClk(refClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rd[4]), .divClk(dclk[4]), .badCode(bad[4]));
  rdiv_top #(.ENC(ENC_PLUS1), .READ_ONLY(1'b1)) uutLock (.refClk(refClk), .rstN(rstN), .wrEn(wrEn),
    .wrData(wrData), .rdData(rd[5]), .divClk(dclk[5]), .badCode(bad[5]));

  function automatic string reqOf(int idx);
    case (idx)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R7";
    endcase
  endfunction

  // Expected divisor: 0 = invalid, 1 = pass-through
  function automatic int expDiv(int idx, int f);
    int d;
    case (idx)
      0, 5: d = f + 1;
      1: d = f;
      2: d = (f == 0) ? 1 : f;
      3: d = 1 << f;
      default: d = (f < 5) ? 2 * f + 3 : 0;
    endcase
    if (d > 255) d = 0;
    return d;
  endfunction

  function automatic void modelWrite(logic [31:0] data);
    for (int idx = 0; idx < NINST; idx++) begin
      if (idx == 5) continue;
      if (idx == 1) begin
        for (int b = 0; b < 4; b++)
          if (data[20 + b]) fieldModel[idx][b] = data[4 + b];
      end else begin
        fieldModel[idx] = int'(data[7:4]);
      end
    end
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doWrite(logic [31:0] data);
    @(negedge refClk);
    wrEn = 1'b1;
    wrData = data;
    modelWrite(data);
    @(negedge refClk);
    wrEn = 1'b0;
  endtask

  // Sample at negedges: find a rising edge, then count the high and low runs
  task automatic measure(int idx, output int hi, output int lo);
    int guard;
    hi = 0; lo = 0; guard = 0;
    while (dclk[idx] !== 1'b0 && guard < 600) begin @(negedge refClk); guard++; end
    while (dclk[idx] !== 1'b1 && guard < 600) begin @(negedge refClk); guard++; end
    while (dclk[idx] === 1'b1 && guard < 900) begin hi++; @(negedge refClk); guard++; end
    while (dclk[idx] === 1'b0 && guard < 1200) begin lo++; @(negedge refClk); guard++; end
  endtask

  task automatic checkInst(int idx);
    int d, hi, lo, lowCnt;
    string req;
    req = reqOf(idx);
    d = expDiv(idx, fieldModel[idx]);
    check(rd[idx] == 32'(fieldModel[idx]) << 4, "R8", $sformatf("%s read-back", req),
          int'(rd[idx]), fieldModel[idx] << 4);
    check(bad[idx] == (d == 0), req, "badCode", int'(bad[idx]), int'(d == 0));
    if (d == 0) begin
      lowCnt = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge refClk);
        if (dclk[idx] === 1'b0) lowCnt++;
      end
      check(lowCnt == 20, req, "invalid code output low samples", lowCnt, 20);
    end else if (d == 1) begin
      @(posedge refClk); #2;
      check(dclk[idx] === 1'b1, req, "bypass high phase", int'(dclk[idx]), 1);
      @(negedge refClk); #2;
      check(dclk[idx] === 1'b0, req, "bypass low phase", int'(dclk[idx]), 0);
    end else begin
      measure(idx, hi, lo);
      check(hi == (d + 1) / 2, $sformatf("%s R10", req), $sformatf("high run div %0d", d), hi, (d + 1) / 2);
      check(lo == d / 2, $sformatf("%s R10", req), $sformatf("low run div %0d", d), lo, d / 2);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge refClk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int hi, lo, hi2, lo2;
    logic [31:0] data;
    void'($urandom(32'h5EED_0042));
    for (int idx = 0; idx < NINST; idx++) fieldModel[idx] = 0;
    repeat (4) @(negedge refClk);
    rstN = 1'b1;
    repeat (3) @(negedge refClk);

    // R11: every copy comes out of reset with a zero field
    for (int idx = 0; idx < NINST; idx++)
      check(rd[idx] == 32'h0, "R11", $sformatf("reset field inst %0d", idx), int'(rd[idx]), 0);
    for (int idx = 0; idx < NINST; idx++) checkInst(idx);

    // R6: empty mask changes nothing, then a masked write sets code 3
    doWrite(32'h0000_FFFF);
    @(negedge refClk);
    check(rd[1] == 32'h0, "R6", "empty mask write", int'(rd[1]), 0);
    doWrite(32'h0030_0030);
    @(negedge refClk);
    check(rd[1] == 32'h30, "R6", "masked write code 3", int'(rd[1]), 32'h30);
    doWrite(32'h0080_0000);
    @(negedge refClk);
    check(rd[1] == 32'h30, "R6", "masked clear of zero bit", int'(rd[1]), 32'h30);

    // R8 and R7: all-ones write lands only in bits 7:4, locked copy stays 0
    doWrite(32'hFFFF_FFFF);
    @(negedge refClk);
    check(rd[0] == 32'hF0, "R8", "field placement", int'(rd[0]), 32'hF0);
    check(rd[5] == 32'h0, "R7", "locked field", int'(rd[5]), 0);
    repeat (SETTLE) @(negedge refClk);
    checkInst(0);

    // R9: divide by 16 running, switch to 2 mid-high; old period must finish
    measure(0, hi, lo);
    while (dclk[0] !== 1'b1) @(negedge refClk);
    hi = 0;
    while (dclk[0] === 1'b1) begin
      hi++;
      if (hi == 3) begin
        wrEn = 1'b1; wrData = 32'h0000_0010; modelWrite(32'h0000_0010);
      end else begin
        wrEn = 1'b0;
      end
      @(negedge refClk);
    end
    wrEn = 1'b0;
    lo = 0;
    while (dclk[0] === 1'b0 && lo < 40) begin lo++; @(negedge refClk); end
    hi2 = 0;
    while (dclk[0] === 1'b1 && hi2 < 40) begin hi2++; @(negedge refClk); end
    lo2 = 0;
    while (dclk[0] === 1'b0 && lo2 < 40) begin lo2++; @(negedge refClk); end
    check(hi == 8, "R9", "old high run kept", hi, 8);
    check(lo == 8, "R9", "old low run kept", lo, 8);
    check(hi2 == 1 && lo2 == 1, "R9", "new period after boundary", hi2 + lo2, 2);

    // Random codes and masks across all copies
    for (int iter = 0; iter < 16; iter++) begin
      data = $urandom;
      if (iter == 0) data = 32'h0000_0000;
      if (iter == 1) data = 32'h00F0_0080;
      doWrite(data);
      repeat (SETTLE) @(negedge refClk);
      for (int idx = 0; idx < NINST; idx++) checkInst(idx);
    end
    finish();
  end
endmodule